// File: doc/BRIEF.md
# Mailbox Command Handshake Sequencer

This block drives one full command exchange against a two-register mailbox that sits on a simple register read/write bus. The mailbox has a data register and an interface register. The top bit of the interface register tells whether the mailbox firmware is still working. A client presents a command byte, a sub-command byte, a parameter and a 32-bit request word, then pulses `start_i`. The sequencer takes the mailbox through this order:

1. Wait until the mailbox is free.
2. Load the request word.
3. Post the command with the busy flag raised.
4. Wait for the firmware to drop the flag.
5. Check the completion byte.
6. Fetch the answer.

It then pulses `done_o` for one cycle, together with a two-bit status, the response word and a slow-response flag.

The sequencer is an FSM with seven states:

| State | What happens in it |
|---|---|
| `S_IDLE` | Waits for `start_i`. |
| `S_PRE_POLL` | Reads the interface register until it is free. |
| `S_WR_DATA` | Writes the request word to the data register. |
| `S_WR_CMD` | Writes the command word to the interface register. |
| `S_POST_POLL` | Reads the interface register until the busy flag clears. |
| `S_RD_RESP` | Reads the data register. |
| `S_FINISH` | Emits the done pulse. |

Its transitions are:

- `IDLE→PRE_POLL` when a start is accepted.
- `PRE_POLL→PRE_POLL` when the read shows busy.
- `PRE_POLL→WR_DATA` when the read shows the mailbox free.
- `WR_DATA→WR_CMD` and `WR_CMD→POST_POLL`, each on an acknowledge.
- `POST_POLL→POST_POLL` when the read shows busy.
- `POST_POLL→RD_RESP` when the flag is clear and the completion byte is zero.
- `POST_POLL→FINISH` when the completion byte is nonzero.
- `RD_RESP→FINISH` on an acknowledge.
- Any bus state `→FINISH` on a bus error, or from a poll state on a timeout.
- `FINISH→IDLE` always.

Each bus access holds its request until the slave acknowledges it. Only one access is outstanding at a time. The two poll phases share one cycle counter. The counter restarts at the start of each phase and converts microsecond limits using the clock frequency parameter.

Top module: `mbox_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `bus_req_o`, `slow_o` and `resp_o` are 0, and `status_o` is 0.
- R2: Before any write, the block reads the interface register (offset 0xA4) repeatedly until bit 31 reads 0.
- R3: The request word is written to the data register (offset 0xA0) before the interface register is written.
- R4: The interface register write carries 1 in bit 31, 0 in bit 30, the parameter's low 14 bits in bits 29:16, the sub-command in bits 15:8 and the command in bits 7:0.
- R5: After the command write, the block reads the interface register until bit 31 is 0. If bits 7:0 are then zero, it reads offset 0xA0 once, returns that word on `resp_o` and reports status 0 (OK).
- R6: A nonzero value in bits 7:0 once the busy flag has cleared gives status 2 (command error) and `resp_o` = 0. The data register is not read.
- R7: A poll read that shows busy after `TMO_US*CLK_MHZ` cycles in the current phase ends the transaction with status 1 (timeout). The cycle count restarts at the start of each poll phase.
- R8: `slow_o` is set when a busy poll read arrives after `SLOW_US*CLK_MHZ` cycles in its phase. Polling continues and the status is unaffected. `slow_o` clears when the next start is accepted.
- R9: A bus acknowledge that carries an error ends the transaction with status 3 (bus error). No further access is issued.
- R10: `done_o` is a single-cycle pulse. A `start_i` that arrives while `busy_o` is high is ignored.
- R11: While a request waits for its acknowledge, the request, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only in idle |
| cmd_i | input | 8 | Command byte |
| sub_i | input | 8 | Sub-command byte |
| prm_i | input | PRM_W | Parameter |
| req_data_i | input | 32 | Request data word |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 OK, 1 timeout, 2 command error, 3 bus error |
| resp_o | output | 32 | Response word (0 unless OK) |
| slow_o | output | 1 | A poll exceeded the slow threshold |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | ADDR_W | Register offset |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_err_i | input | 1 | Error flag, valid with acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
With the bench's slave, which acknowledges one cycle after each request, every access takes two cycles. Each busy poll therefore adds two cycles, and `done_o` rises one cycle after the final acknowledge. `status_o`, `resp_o` and `slow_o` are updated on that same edge. The bench waits for `done_o` at falling edges, samples all results in that cycle, and checks that the next falling edge shows `done_o` low. Poll counts and access order are recorded by the slave model and compared with counts computed from the busy durations the bench programs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int          WORD_W   = 32;
    localparam int          BUSY_BIT = 31;
    localparam logic [7:0]  DATA_OFS = 8'hA0;
    localparam logic [7:0]  IFC_OFS  = 8'hA4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_POLL,
        S_WR_DATA,
        S_WR_CMD,
        S_POST_POLL,
        S_RD_RESP,
        S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TMO     = 2'd1,
        ST_CMD_ERR = 2'd2,
        ST_BUS_ERR = 2'd3
    } seq_status_e;

endpackage

// File: rtl/mbox_cmd_pack.sv
module mbox_cmd_pack
    import mbox_pkg::*;
#(
    parameter int PRM_W = 14
) (
    input  logic [7:0]        cmd_i,
    input  logic [7:0]        sub_i,
    input  logic [PRM_W-1:0]  prm_i,
    output logic [WORD_W-1:0] word_o
);
    // Field between the busy flag and the sub-command byte.
    localparam int FLD_W = BUSY_BIT - 16;

    logic [FLD_W-1:0] prm_fld;

    generate
        if (PRM_W >= FLD_W) begin : g_trunc
            assign prm_fld = prm_i[FLD_W-1:0];
        end else begin : g_zext
            assign prm_fld = {{(FLD_W-PRM_W){1'b0}}, prm_i};
        end
    endgenerate

    assign word_o = {1'b1, prm_fld, sub_i, cmd_i};

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int SLOW_CYC = 40,
    parameter int TMO_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic slow_hit_o,
    output logic tmo_hit_o
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && (cnt_q < CW'(TMO_CYC))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slow_hit_o = (cnt_q >= CW'(SLOW_CYC));
    assign tmo_hit_o  = (cnt_q >= CW'(TMO_CYC));

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int CLK_MHZ = 250,
    parameter int SLOW_US = 40,
    parameter int TMO_US  = 1000,
    parameter int ADDR_W  = 8,
    parameter int PRM_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        cmd_i,
    input  logic [7:0]        sub_i,
    input  logic [PRM_W-1:0]  prm_i,
    input  logic [31:0]       req_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [31:0]       resp_o,
    output logic              slow_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [31:0]       bus_rdata_i
);
    localparam int SLOW_CYC = SLOW_US * CLK_MHZ;
    localparam int TMO_CYC  = TMO_US * CLK_MHZ;
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_IFC  = ADDR_W'(IFC_OFS);

    seq_state_e  st_q, st_d;
    seq_status_e fin_st_d;
    seq_status_e status_q;
    logic        cap_resp;
    logic        in_poll, nxt_poll, tmr_clr;
    logic        slow_hit, tmo_hit;
    logic        acc_ok, rd_busy;
    logic [31:0] word_w, word_q, data_q, resp_q;
    logic        done_q, slow_q;

    mbox_cmd_pack #(.PRM_W(PRM_W)) u_pack (
        .cmd_i  (cmd_i),
        .sub_i  (sub_i),
        .prm_i  (prm_i),
        .word_o (word_w)
    );

    assign in_poll  = (st_q == S_PRE_POLL) || (st_q == S_POST_POLL);
    assign nxt_poll = (st_d == S_PRE_POLL) || (st_d == S_POST_POLL);
    assign tmr_clr  = nxt_poll && (st_d != st_q);

    mbox_poll_timer #(.SLOW_CYC(SLOW_CYC), .TMO_CYC(TMO_CYC)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tmr_clr),
        .en_i       (in_poll),
        .slow_hit_o (slow_hit),
        .tmo_hit_o  (tmo_hit)
    );

    assign acc_ok  = bus_ack_i && !bus_err_i;
    assign rd_busy = acc_ok && bus_rdata_i[BUSY_BIT];

    // Next-state decision
    always_comb begin
        st_d     = st_q;
        fin_st_d = ST_OK;
        cap_resp = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start_i) st_d = S_PRE_POLL;
            end
            S_PRE_POLL: begin
                if (bus_ack_i && bus_err_i) begin
                    st_d = S_FINISH; fin_st_d = ST_BUS_ERR;
                end else if (rd_busy) begin
                    if (tmo_hit) begin
                        st_d = S_FINISH; fin_st_d = ST_TMO;
                    end
                end else if (acc_ok) begin
                    st_d = S_WR_DATA;
                end
            end
            S_WR_DATA: begin
                if (bus_ack_i && bus_err_i) begin
                    st_d = S_FINISH; fin_st_d = ST_BUS_ERR;
                end else if (acc_ok) begin
                    st_d = S_WR_CMD;
                end
            end
            S_WR_CMD: begin
                if (bus_ack_i && bus_err_i) begin
                    st_d = S_FINISH; fin_st_d = ST_BUS_ERR;
                end else if (acc_ok) begin
                    st_d = S_POST_POLL;
                end
            end
            S_POST_POLL: begin
                if (bus_ack_i && bus_err_i) begin
                    st_d = S_FINISH; fin_st_d = ST_BUS_ERR;
                end else if (rd_busy) begin
                    if (tmo_hit) begin
                        st_d = S_FINISH; fin_st_d = ST_TMO;
                    end
                end else if (acc_ok) begin
                    if (bus_rdata_i[7:0] != 8'h00) begin
                        st_d = S_FINISH; fin_st_d = ST_CMD_ERR;
                    end else begin
                        st_d = S_RD_RESP;
                    end
                end
            end
            S_RD_RESP: begin
                if (bus_ack_i && bus_err_i) begin
                    st_d = S_FINISH; fin_st_d = ST_BUS_ERR;
                end else if (acc_ok) begin
                    st_d = S_FINISH; cap_resp = 1'b1;
                end
            end
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Registered results and latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            status_q <= ST_OK;
            resp_q   <= '0;
            slow_q   <= 1'b0;
            word_q   <= '0;
            data_q   <= '0;
        end else begin
            done_q <= (st_d == S_FINISH);
            if (st_q == S_IDLE && start_i) begin
                word_q <= word_w;
                data_q <= req_data_i;
                resp_q <= '0;
                slow_q <= 1'b0;
            end
            if (st_q != S_FINISH && st_d == S_FINISH) status_q <= fin_st_d;
            if (cap_resp) resp_q <= bus_rdata_i;
            if (in_poll && rd_busy && slow_hit) slow_q <= 1'b1;
        end
    end

    // Bus drive from state
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = A_IFC;
        bus_wdata_o = '0;
        unique case (st_q)
            S_PRE_POLL, S_POST_POLL: bus_req_o = 1'b1;
            S_WR_DATA: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_DATA; bus_wdata_o = data_q;
            end
            S_WR_CMD: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_wdata_o = word_q;
            end
            S_RD_RESP: begin
                bus_req_o = 1'b1; bus_addr_o = A_DATA;
            end
            default: bus_req_o = 1'b0;
        endcase
    end

    assign busy_o   = (st_q != S_IDLE);
    assign done_o   = done_q;
    assign status_o = status_q;
    assign resp_o   = resp_q;
    assign slow_o   = slow_q;

endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [31:0]       bus_wdata_o,
    input logic              bus_ack_i,
    input logic              bus_err_i
);
    localparam logic [ADDR_W-1:0] A_IFC = ADDR_W'(8'hA4);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
            && $stable(bus_we_o) && $stable(bus_wdata_o)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_start_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_cmd_busy_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && bus_addr_o == A_IFC) |-> bus_wdata_o[31]);

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack_i && bus_err_i) |=> !bus_req_o);

endmodule

bind mbox_seq mbox_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i)
);

// File: tb/mbox_seq_bench.sv
`timescale 1ns/1ps
module mbox_seq_bench;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  sub;
        logic [15:0] prm;
        logic [31:0] dat;
        logic [15:0] pre;   // busy reads before free; FFFF = forever
        logic [15:0] post;  // busy reads after command; FFFF = forever
        logic [7:0]  cc;
        logic [1:0]  st;
        logic        slow;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h02, 16'h0005, 32'h12345678, 16'd0,     16'd0,     8'h00, 2'd0, 1'b0},
        '{8'h7F, 8'h00, 16'hFFFF, 32'hDEADBEEF, 16'd3,     16'd5,     8'h00, 2'd0, 1'b0},
        '{8'h10, 8'h20, 16'h1234, 32'hCAFEF00D, 16'd0,     16'd30,    8'h00, 2'd0, 1'b1},
        '{8'h22, 8'h33, 16'h0001, 32'h00000000, 16'd0,     16'd2,     8'h5A, 2'd2, 1'b0},
        '{8'h44, 8'h55, 16'h0000, 32'h11111111, 16'd0,     16'hFFFF,  8'h00, 2'd1, 1'b1},
        '{8'hAA, 8'hBB, 16'h2000, 32'h00000005, 16'd25,    16'd0,     8'h00, 2'd0, 1'b1},
        '{8'h3C, 8'h01, 16'h0100, 32'h00000077, 16'hFFFF,  16'd0,     8'h00, 2'd1, 1'b1},
        '{8'h05, 8'h06, 16'h0003, 32'hABCD0123, 16'd300,   16'd300,   8'h00, 2'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  cmd_i = '0, sub_i = '0;
    logic [13:0] prm_i = '0;
    logic [31:0] req_data_i = '0;
    logic        busy_o, done_o, slow_o;
    logic [1:0]  status_o;
    logic [31:0] resp_o;
    logic        bus_req_o, bus_we_o;
    logic [7:0]  bus_addr_o;
    logic [31:0] bus_wdata_o;
    logic        bus_ack_i = 1'b0, bus_err_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;

    always #2 clk = ~clk;

    mbox_seq #(.CLK_MHZ(1), .SLOW_US(40), .TMO_US(1000), .ADDR_W(8), .PRM_W(14)) u_mbox_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .sub_i(sub_i),
        .prm_i(prm_i), .req_data_i(req_data_i), .busy_o(busy_o), .done_o(done_o),
        .status_o(status_o), .resp_o(resp_o), .slow_o(slow_o), .bus_req_o(bus_req_o),
        .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i), .bus_rdata_i(bus_rdata_i)
    );

    // Mailbox slave with scripted firmware
    logic        clr_stats = 1'b0;
    logic        err_on_dwr = 1'b0;
    logic [15:0] cur_pre = '0, cur_post = '0;
    logic [7:0]  cur_cc = '0;
    logic [15:0] pre_left, post_left;
    logic [31:0] data_reg, last_cmd, last_dwr;
    int          n_pre_rd, n_post_rd, n_dwr, n_cwr, n_drd, n_done;
    logic        order_bad;

    always @(posedge clk) begin
        if (clr_stats) begin
            pre_left <= cur_pre; post_left <= cur_post;
            n_pre_rd <= 0; n_post_rd <= 0; n_dwr <= 0; n_cwr <= 0; n_drd <= 0; n_done <= 0;
            order_bad <= 1'b0; last_cmd <= '0; last_dwr <= '0; data_reg <= '0;
        end else begin
            if (done_o) n_done <= n_done + 1;
        end
        if (!rst_n) begin
            bus_ack_i <= 1'b0; bus_err_i <= 1'b0; bus_rdata_i <= '0;
        end else if (bus_req_o && !bus_ack_i) begin
            bus_ack_i <= 1'b1; bus_err_i <= 1'b0; bus_rdata_i <= '0;
            if (bus_we_o) begin
                if (bus_addr_o == 8'hA0) begin
                    if (err_on_dwr) bus_err_i <= 1'b1;
                    else begin data_reg <= bus_wdata_o; last_dwr <= bus_wdata_o; n_dwr <= n_dwr + 1; end
                end else if (bus_addr_o == 8'hA4) begin
                    n_cwr <= n_cwr + 1; last_cmd <= bus_wdata_o;
                    if (n_dwr == 0) order_bad <= 1'b1;
                end
            end else if (bus_addr_o == 8'hA4) begin
                if (n_cwr == 0) begin
                    n_pre_rd <= n_pre_rd + 1;
                    if (pre_left != 0) begin
                        bus_rdata_i <= 32'h8000_0000;
                        if (pre_left != 16'hFFFF) pre_left <= pre_left - 1;
                    end
                end else begin
                    n_post_rd <= n_post_rd + 1;
                    if (post_left != 0) begin
                        bus_rdata_i <= {1'b1, last_cmd[30:0]};
                        if (post_left != 16'hFFFF) post_left <= post_left - 1;
                    end else begin
                        bus_rdata_i <= {1'b0, last_cmd[30:8], cur_cc};
                    end
                end
            end else if (bus_addr_o == 8'hA0) begin
                n_drd <= n_drd + 1;
                bus_rdata_i <= ~data_reg;
            end
        end else begin
            bus_ack_i <= 1'b0; bus_err_i <= 1'b0;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic prep(input logic [15:0] pre, input logic [15:0] post, input logic [7:0] cc);
        @(negedge clk);
        cur_pre = pre; cur_post = post; cur_cc = cc; clr_stats = 1'b1;
        @(negedge clk);
        clr_stats = 1'b0;
    endtask

    task automatic launch(input logic [7:0] c, input logic [7:0] s, input logic [15:0] p, input logic [31:0] d);
        cmd_i = c; sub_i = s; prm_i = p[13:0]; req_data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            if (done_o) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        logic [31:0] exp_cmd, exp_resp;
        logic pre_to;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !bus_req_o && !slow_o, "R1 idle flags",
            {busy_o, done_o, bus_req_o, slow_o}, 0);
        chk(status_o == 2'd0 && resp_o == 0, "R1 status/resp", {status_o, resp_o[29:0]}, 0);

        for (int v = 0; v < NV; v++) begin
            prep(VECS[v].pre, VECS[v].post, VECS[v].cc);
            launch(VECS[v].cmd, VECS[v].sub, VECS[v].prm, VECS[v].dat);
            wait_done(seen);
            chk(seen, "R10 done arrives", seen, 1);
            pre_to   = (VECS[v].pre == 16'hFFFF);
            exp_cmd  = {2'b10, VECS[v].prm[13:0], VECS[v].sub, VECS[v].cmd};
            exp_resp = (VECS[v].st == 2'd0) ? ~VECS[v].dat : 32'h0;
            // R5 R6 R7 status and response
            chk(status_o == VECS[v].st, "R5/R6/R7 status", status_o, VECS[v].st);
            chk(resp_o == exp_resp, "R5/R6 response", resp_o, exp_resp);
            chk(slow_o == VECS[v].slow, "R8 slow flag", slow_o, VECS[v].slow);
            @(negedge clk);
            chk(!done_o, "R10 done one cycle", done_o, 0);
            if (pre_to) begin
                chk(n_dwr == 0 && n_cwr == 0, "R2 no write while busy", n_dwr + n_cwr, 0);
            end else begin
                chk(n_pre_rd == VECS[v].pre + 1, "R2 idle poll count", n_pre_rd, VECS[v].pre + 1);
                chk(!order_bad && n_dwr == 1 && last_dwr == VECS[v].dat, "R3 data first",
                    last_dwr, VECS[v].dat);
                chk(n_cwr == 1 && last_cmd == exp_cmd, "R4 command word", last_cmd, exp_cmd);
                if (VECS[v].post != 16'hFFFF)
                    chk(n_post_rd == VECS[v].post + 1, "R5 completion poll count",
                        n_post_rd, VECS[v].post + 1);
                chk(n_drd == ((VECS[v].st == 2'd0) ? 1 : 0), "R5/R6 data reads", n_drd,
                    (VECS[v].st == 2'd0) ? 1 : 0);
            end
        end

        // R9 bus error on data write
        err_on_dwr = 1'b1;
        prep(16'd0, 16'd0, 8'h00);
        launch(8'h09, 8'h08, 16'h0007, 32'h0BADF00D);
        wait_done(seen);
        chk(seen && status_o == 2'd3, "R9 bus error status", status_o, 3);
        @(negedge clk);
        chk(n_cwr == 0 && n_post_rd == 0, "R9 no access after error", n_cwr + n_post_rd, 0);
        err_on_dwr = 1'b0;

        // R10 start while busy is ignored
        prep(16'd2, 16'd4, 8'h00);
        launch(8'h31, 8'h32, 16'h0033, 32'h00000034);
        repeat (3) @(negedge clk);
        launch(8'hEE, 8'hEE, 16'h3EEE, 32'hEEEEEEEE);
        wait_done(seen);
        repeat (30) @(negedge clk);
        chk(n_cwr == 1 && last_cmd == 32'h80333231, "R10 second start ignored", last_cmd, 32'h80333231);
        chk(n_done == 1 && !busy_o, "R10 single done", n_done, 1);
        chk(resp_o == 32'hFFFFFFCB, "R10 response of first", resp_o, 32'hFFFFFFCB);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule